// File: doc/BRIEF.md
# Debug Serial Port Front End

This block sits between an off-chip debug host and the core clock domain. The host supplies a slow serial clock and a serial data line. Neither is related to the core clock. Each input passes through a chain of synchronizer flops. The block then oversamples the synchronized serial clock with the core clock. A new serial clock level is accepted only after it has read the same on two consecutive core edges, so short spikes are discarded.

Each accepted low-to-high transition of the filtered serial clock is one bit slot. In that core cycle the block does three things:

- shifts the synchronized data bit into a receive register;
- moves the next bit of a transmit register onto the serial output flop;
- advances a bit counter.

When the counter reaches the configured frame length, a one-cycle done strobe marks a complete received word. The command decoder beyond this block reads that word. It can also hand back a parallel response word with a load strobe, and that word is sent most significant bit first.

Top module: `dbgser_front`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block clears the receive register, the bit counter, the transmit register and the filter state. After that edge `sdo` is 0, `rx_word` is 0 and `frame_done` is 0.
- R2: A high pulse on `sclk_in` that is seen by only one rising `clk` edge is ignored. `sdo`, `rx_word` and the bit count stay as they were.
- R3: When `sclk_in` goes high and stays high, take the first rising `clk` edge that samples it high as edge 1. The outputs keep their old values through edge 3 and take their new values at edge 4.
- R4: On each accepted rise, `rx_word` shifts one place toward the MSB and takes the synchronized `sdi_in` bit into bit 0.
- R5: The FRAME_W-th accepted rise since reset or since the previous frame raises `frame_done` for exactly one `clk` cycle. In that same cycle `rx_word` holds the whole frame, with the first-received bit in the MSB.
- R6: A `tx_load` pulse copies `tx_word` into the transmit register. On the following accepted rises, `sdo` presents `tx_word` bits from bit FRAME_W-1 down to bit 0, one bit per rise.
- R7: `sdo` changes only on the `clk` edge that completes an accepted rise. Otherwise it holds its value.
- R8: An accepted falling level of `sclk_in` changes neither `sdo` nor `rx_word`.
- R9: After a frame completes, the bit counter restarts. Every further group of FRAME_W accepted rises produces exactly one more `frame_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial clock from the host, at most one fifth of the `clk` rate |
| sdi_in | input | 1 | Asynchronous serial data from the host |
| sdo | output | 1 | Registered serial data to the host |
| tx_word | input | FRAME_W | Parallel response word |
| tx_load | input | 1 | Loads `tx_word` into the transmit register |
| rx_word | output | FRAME_W | Receive shift register contents |
| frame_done | output | 1 | One-cycle strobe when the last bit of a frame is captured |

## Verification
The bound checker watches, on every cycle:

- that `sdo` and `rx_word` stay frozen on any cycle without an accepted rise;
- that the filtered level never flips unless the synchronized clock has held the new value for two samples;
- that the done strobe lasts one cycle and only follows an accepted rise;
- that reset clears the outputs.

Some behaviours need the bench's scenarios, because they depend on the relation between the stimulus and the outputs. These are:

- the exact four-edge latency from a serial clock rise to the output change;
- the bit order of received frames and transmitted responses;
- rejection of a one-cycle glitch;
- frame boundaries across several consecutive frames.

// File: rtl/dbgser_pkg.sv
package dbgser_pkg;

    // Default frame length in bits
    localparam int DBG_FRAME_W = 17;
    // Default synchronizer depth
    localparam int DBG_SYNC_N = 2;

    // Deglitch filter state: last synchronized sample and accepted level
    typedef struct packed {
        logic prev;
        logic lvl;
    } flt_state_t;

    // Filter events derived for one core cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } flt_event_t;

    // A level is accepted when two consecutive samples agree and differ from the accepted level
    function automatic logic flt_accept(input flt_state_t st, input logic smp);
        return (smp == st.prev) && (smp != st.lvl);
    endfunction

    function automatic flt_state_t flt_next(input flt_state_t st, input logic smp);
        flt_state_t nx;
        nx.prev = smp;
        nx.lvl  = flt_accept(st, smp) ? smp : st.lvl;
        return nx;
    endfunction

    function automatic flt_event_t flt_events(input flt_state_t st, input logic smp);
        flt_event_t ev;
        ev.rise = flt_accept(st, smp) && smp;
        ev.fall = flt_accept(st, smp) && !smp;
        return ev;
    endfunction

endpackage

// File: rtl/dbgser_sync.sv
module dbgser_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = dbgser_pkg::DBG_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain[0] <= d_async[b];
                for (int s = 1; s < STAGES; s++) begin
                    chain[s] <= chain[s-1];
                end
            end
        end
        assign q_sync[b] = chain[LAST];
    end

endmodule

// File: rtl/dbgser_filter.sv
module dbgser_filter
    import dbgser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smp,
    output logic lvl,
    output logic rise
);
    flt_state_t st_q;
    flt_state_t st_d;
    flt_event_t ev;

    always_comb begin
        st_d = flt_next(st_q, smp);
        ev   = flt_events(st_q, smp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.lvl;
    assign rise = ev.rise;

endmodule

// File: rtl/dbgser_shifter.sv
module dbgser_shifter #(
    parameter int FRAME_W = dbgser_pkg::DBG_FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rise,
    input  logic               sdi_bit,
    input  logic               tx_load,
    input  logic [FRAME_W-1:0] tx_word,
    output logic [FRAME_W-1:0] rx_word,
    output logic               frame_done,
    output logic               sdo
);
    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] rx_q;
    logic [FRAME_W-1:0] tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               done_q;
    logic               sdo_q;

    // Receive side: shift toward MSB, count bits, flag the last one
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (rise) begin
                rx_q <= {rx_q[FRAME_W-2:0], sdi_bit};
                if (cnt_q == CNT_LAST) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Transmit side: load has priority, otherwise shift out MSB first
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (rise) begin
                sdo_q <= tx_q[FRAME_W-1];
            end
            if (tx_load) begin
                tx_q <= tx_word;
            end else if (rise) begin
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign rx_word    = rx_q;
    assign frame_done = done_q;
    assign sdo        = sdo_q;

endmodule

// File: rtl/dbgser_front.sv
module dbgser_front #(
    parameter int FRAME_W     = dbgser_pkg::DBG_FRAME_W,
    parameter int SYNC_STAGES = dbgser_pkg::DBG_SYNC_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_in,
    input  logic               sdi_in,
    output logic               sdo,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               tx_load,
    output logic [FRAME_W-1:0] rx_word,
    output logic               frame_done
);
    logic [1:0] sync_q;
    logic       sclk_s;
    logic       sdi_s;
    logic       flt_lvl;
    logic       flt_rise;

    // Both inputs share one synchronizer so data stays aligned with the clock
    dbgser_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({sdi_in, sclk_in}),
        .q_sync  (sync_q)
    );

    assign sclk_s = sync_q[0];
    assign sdi_s  = sync_q[1];

    dbgser_filter u_filter (
        .clk  (clk),
        .rst  (rst),
        .smp  (sclk_s),
        .lvl  (flt_lvl),
        .rise (flt_rise)
    );

    dbgser_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .rise       (flt_rise),
        .sdi_bit    (sdi_s),
        .tx_load    (tx_load),
        .tx_word    (tx_word),
        .rx_word    (rx_word),
        .frame_done (frame_done),
        .sdo        (sdo)
    );

endmodule

// File: rtl/dbgser_front_chk.sv
module dbgser_front_chk #(
    parameter int FRAME_W = dbgser_pkg::DBG_FRAME_W
) (
    input logic               clk,
    input logic               rst,
    input logic               sclk_s,
    input logic               flt_lvl,
    input logic               flt_rise,
    input logic               sdo,
    input logic [FRAME_W-1:0] rx_word,
    input logic               frame_done
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sdo == 1'b0 && rx_word == '0 && !frame_done)); // R1

    AST_LEVEL_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
        (flt_lvl != $past(flt_lvl)) |-> ($past(sclk_s) == flt_lvl && $past(sclk_s, 2) == flt_lvl)); // R2

    AST_RISE_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        flt_rise |=> flt_lvl); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R5

    AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(flt_rise)); // R5

    AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !flt_rise |=> $stable(sdo)); // R7

    AST_RX_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !flt_rise |=> $stable(rx_word)); // R8

endmodule

bind dbgser_front dbgser_front_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (sclk_s),
    .flt_lvl    (flt_lvl),
    .flt_rise   (flt_rise),
    .sdo        (sdo),
    .rx_word    (rx_word),
    .frame_done (frame_done)
);

// File: tb/dbgser_front_test.sv
module dbgser_front_test;
    localparam int FW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk_in = 1'b0;
    logic          sdi_in = 1'b0;
    logic          sdo;
    logic [FW-1:0] tx_word = '0;
    logic          tx_load = 1'b0;
    logic [FW-1:0] rx_word;
    logic          frame_done;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    bit finished = 0;
    bit last_done = 0;
    logic          last_sdo;
    logic [FW-1:0] last_rx;
    logic [FW-1:0] exp_q[$];

    always #5 clk = ~clk;

    dbgser_front uut (
        .clk        (clk),
        .rst        (rst),
        .sclk_in    (sclk_in),
        .sdi_in     (sdi_in),
        .sdo        (sdo),
        .tx_word    (tx_word),
        .tx_load    (tx_load),
        .rx_word    (rx_word),
        .frame_done (frame_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected frames as the design announces them
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_done) begin
                frames_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected frame", 32'(rx_word), 32'h0);
                end else begin
                    logic [FW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rx_word == e, "R5 frame contents", 32'(rx_word), 32'(e));
                end
                chk(!last_done, "R5 strobe width", 32'(last_done), 32'h0);
            end
            last_done = frame_done;
        end
    end

    // One serial bit: low phase, then rise with latency checks, then high phase
    task automatic send_bit(input logic b, input logic exp_sdo);
        @(negedge clk);
        sclk_in = 1'b0;
        sdi_in  = b;
        repeat (5) @(negedge clk);
        chk(sdo == last_sdo, "R8 sdo after fall", 32'(sdo), 32'(last_sdo));
        chk(rx_word == last_rx, "R8 rx after fall", 32'(rx_word), 32'(last_rx));
        sclk_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sdo == last_sdo, "R3 no change by edge 3", 32'(sdo), 32'(last_sdo));
        chk(rx_word == last_rx, "R3 rx unchanged by edge 3", 32'(rx_word), 32'(last_rx));
        @(posedge clk);
        @(negedge clk);
        chk(sdo == exp_sdo, "R6 sdo bit", 32'(sdo), 32'(exp_sdo));
        chk(rx_word == {last_rx[FW-2:0], b}, "R4 rx shift", 32'(rx_word), 32'({last_rx[FW-2:0], b}));
        last_sdo = sdo;
        last_rx  = rx_word;
        repeat (3) @(negedge clk);
    endtask

    // Driver: load the response, queue the expected frame, send the bits
    task automatic send_frame(input logic [FW-1:0] rx_val, input logic [FW-1:0] tx_val);
        @(negedge clk);
        tx_word = tx_val;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        last_sdo = sdo;
        last_rx  = rx_word;
        exp_q.push_back(rx_val);
        for (int i = FW - 1; i >= 0; i--) begin
            send_bit(rx_val[i], tx_val[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sdo == 1'b0, "R1 sdo reset", 32'(sdo), 32'h0);
        chk(rx_word == '0, "R1 rx reset", 32'(rx_word), 32'h0);
        chk(frame_done == 1'b0, "R1 done reset", 32'(frame_done), 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        send_frame(17'h1A5C3, 17'h15A5A);

        // One-cycle glitch between frames must be ignored
        begin
            logic          g_sdo;
            logic [FW-1:0] g_rx;
            g_sdo = sdo;
            g_rx  = rx_word;
            sclk_in = 1'b0;
            repeat (5) @(negedge clk);
            sclk_in = 1'b1;
            @(negedge clk);
            sclk_in = 1'b0;
            repeat (8) @(negedge clk);
            chk(sdo == g_sdo, "R2 glitch sdo", 32'(sdo), 32'(g_sdo));
            chk(rx_word == g_rx, "R2 glitch rx", 32'(rx_word), 32'(g_rx));
        end

        send_frame(17'h0FFFF, 17'h10001);
        send_frame(17'h00000, 17'h1FFFF);

        repeat (6) @(negedge clk);
        chk(frames_seen == 3, "R9 frame count", 32'(frames_seen), 32'd3);
        chk(exp_q.size() == 0, "R9 queue drained", 32'(exp_q.size()), 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule